// File: doc/BRIEF.md
# Packed Halfword Exchange Subtract-Add Unit

This block performs one packed arithmetic step on two 32-bit operands, each holding two unsigned 16-bit lanes. The halves of the second operand trade places first, so the upper lane of the result is the first operand's upper half minus the second operand's lower half, and the lower lane is the first operand's lower half plus the second operand's upper half. Both lanes wrap modulo 2^16. A 4-bit greater-or-equal field reports, per lane, whether the subtraction avoided a borrow (bits 3:2) and whether the addition carried out of bit 15 (bits 1:0). Each pair of bits is written together.

An operand pair is accepted on any clock edge where `in_valid` is high. The result and flags are registered on that edge, and `res_valid` is high for exactly the following cycle. A small control machine tracks the output register. It has three states: `ST_IDLE` (nothing captured since reset), `ST_FRESH` (captured on the last edge), and `ST_HOLD` (an older value is being held). The transitions are: *accept* (any state to `ST_FRESH` when `in_valid` is high), *age* (`ST_FRESH` to `ST_HOLD` when `in_valid` is low), *wait* (`ST_IDLE` stays in `ST_IDLE`), *keep* (`ST_HOLD` stays in `ST_HOLD`), and *clear* (any state to `ST_IDLE` on reset). No other status output exists.

Top module: `hsx_unit`

## Requirements
- R1: After an accepting edge, `res[31:16]` equals (`op_a[31:16]` − `op_b[15:0]`) mod 2^16, using the operands present at that edge.
- R2: After an accepting edge, `res[15:0]` equals (`op_a[15:0]` + `op_b[31:16]`) mod 2^16.
- R3: `ge[3:2]` is 11 when unsigned `op_a[31:16]` ≥ `op_b[15:0]` (no borrow), and 00 otherwise.
- R4: `ge[1:0]` is 11 when `op_a[15:0]` + `op_b[31:16]` ≥ 2^16 (carry out of bit 15), and 00 otherwise.
- R5: Neither pair in `ge` ever holds 01 or 10.
- R6: A synchronous active-high `rst` sets `res`, `ge` and `res_valid` to zero on the next edge.
- R7: `res_valid` is high in the cycle after each edge where `in_valid` was high, and low in every other cycle. Each accepted pair produces exactly one valid result, in order.
- R8: While `in_valid` is low, `res` and `ge` keep their values whatever the operands do.
- R9: Equal values in `op_a[31:16]` and `op_b[15:0]` give an upper result of 0 with `ge[3:2]`=11. A lower sum of exactly 0x10000 gives a lower result of 0 with `ge[1:0]`=11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands valid; captured on this edge |
| op_a | input | 32 | First operand, two packed unsigned halfwords |
| op_b | input | 32 | Second operand; its halves are exchanged before use |
| res | output | 32 | Registered packed result |
| res_valid | output | 1 | High for one cycle after each capture |
| ge | output | 4 | Registered flags: [3:2] no borrow in the upper lane, [1:0] carry in the lower lane |

## Verification
A wrong control state shows at `res_valid` in the very next cycle. A machine stuck in `ST_FRESH` leaves valid high for an extra cycle, which the scoreboard sees as a result with no pending item. A wrongly taken *accept* shows as an unexpected capture, which also breaks the hold check on `res` and `ge`. A faulty lane or flag derivation is visible one cycle after the capturing edge, when the scoreboard compares each field, including the exact-equality and exact-0x10000 corners where the borrow and carry decisions flip.

// File: rtl/hsx_pkg.sv
package hsx_pkg;

    // Output register state
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRESH = 2'd1,
        ST_HOLD  = 2'd2
    } hsx_state_e;

    localparam int GE_PAIRS = 2;
    localparam int GE_W     = 2 * GE_PAIRS;

endpackage

// File: rtl/hsx_lane.sv
// One packed lane: either a subtract reporting "no borrow"
// or an add reporting "carry out".
module hsx_lane #(
    parameter int LANE_W = 16,
    parameter bit IS_SUB = 1'b0
) (
    input  logic [LANE_W-1:0] lhs,
    input  logic [LANE_W-1:0] rhs,
    output logic [LANE_W-1:0] value,
    output logic              flag
);

    logic [LANE_W:0] wide;

    generate
        if (IS_SUB) begin : g_sub
            // lhs + ~rhs + 1: the top bit is 1 exactly when no borrow occurs
            always_comb wide = {1'b0, lhs} + {1'b0, ~rhs} + {{LANE_W{1'b0}}, 1'b1};
        end else begin : g_add
            always_comb wide = {1'b0, lhs} + {1'b0, rhs};
        end
    endgenerate

    assign value = wide[LANE_W-1:0];
    assign flag  = wide[LANE_W];

endmodule

// File: rtl/hsx_ctrl.sv
// Tracks the output register: empty, freshly written, or holding.
module hsx_ctrl
    import hsx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic capture,
    output logic out_valid
);

    hsx_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = in_valid ? ST_FRESH : ST_IDLE;
            ST_FRESH: state_d = in_valid ? ST_FRESH : ST_HOLD;
            ST_HOLD:  state_d = in_valid ? ST_FRESH : ST_HOLD;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        capture   = in_valid;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  out_valid = 1'b0;
            ST_FRESH: out_valid = 1'b1;
            ST_HOLD:  out_valid = 1'b0;
            default:  out_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/hsx_unit.sv
// Packed halfword subtract-add with operand exchange, registered output.
module hsx_unit
    import hsx_pkg::*;
#(
    parameter int LANE_W = 16,
    localparam int DATA_W = 2 * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic [DATA_W-1:0] res,
    output logic              res_valid,
    output logic [GE_W-1:0]   ge
);

    logic [LANE_W-1:0] hi_val, lo_val;
    logic              no_borrow, carry_out;
    logic              capture;
    logic [LANE_W-1:0] b_swap_hi, b_swap_lo;

    // exchange the halves of the second operand
    assign b_swap_hi = op_b[LANE_W-1:0];
    assign b_swap_lo = op_b[DATA_W-1:LANE_W];

    hsx_lane #(.LANE_W(LANE_W), .IS_SUB(1'b1)) u_hi (
        .lhs  (op_a[DATA_W-1:LANE_W]),
        .rhs  (b_swap_hi),
        .value(hi_val),
        .flag (no_borrow)
    );

    hsx_lane #(.LANE_W(LANE_W), .IS_SUB(1'b0)) u_lo (
        .lhs  (op_a[LANE_W-1:0]),
        .rhs  (b_swap_lo),
        .value(lo_val),
        .flag (carry_out)
    );

    hsx_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .capture  (capture),
        .out_valid(res_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
            ge  <= '0;
        end else if (capture) begin
            res <= {hi_val, lo_val};
            ge  <= {{GE_PAIRS{no_borrow}}, {GE_PAIRS{carry_out}}};
        end
    end

endmodule

// File: rtl/hsx_unit_chk.sv
module hsx_unit_chk #(
    parameter int LANE_W = 16,
    localparam int DATA_W = 2 * LANE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] op_a,
    input logic [DATA_W-1:0] op_b,
    input logic [DATA_W-1:0] res,
    input logic              res_valid,
    input logic [3:0]        ge
);

    p_reset_clears_r6: assert property (@(posedge clk)
        rst |=> (res == '0 && ge == '0 && !res_valid));

    p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);

    p_no_spurious_valid_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !$past(rst)) |=> ($stable(res) && $stable(ge)));

    p_pairs_r5: assert property (@(posedge clk) disable iff (rst)
        (ge[3] == ge[2]) && (ge[1] == ge[0]));

    p_upper_lane_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res[DATA_W-1:LANE_W] ==
            LANE_W'($past(op_a[DATA_W-1:LANE_W]) - $past(op_b[LANE_W-1:0])));

    p_no_borrow_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ge[3] == ($past(op_a[DATA_W-1:LANE_W]) >= $past(op_b[LANE_W-1:0])));

endmodule

bind hsx_unit hsx_unit_chk #(.LANE_W(LANE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .res      (res),
    .res_valid(res_valid),
    .ge       (ge)
);

// File: tb/test_hsx_unit.sv
module test_hsx_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [31:0] res;
    logic        res_valid;
    logic [3:0]  ge;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [35:0] sb_q[$];   // {ge, res}
    logic [35:0] last_exp = '0;

    always #5 clk = ~clk;

    hsx_unit i_hsx_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b),
        .res(res), .res_valid(res_valid), .ge(ge)
    );

    function automatic logic [35:0] model(input logic [31:0] a, input logic [31:0] b);
        logic [16:0] s;
        logic [15:0] d;
        logic        nb;
        s  = {1'b0, a[15:0]} + {1'b0, b[31:16]};
        d  = a[31:16] - b[15:0];
        nb = (a[31:16] >= b[15:0]);
        return {{nb, nb, s[16], s[16]}, d, s[15:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_a = a; op_b = b; in_valid = 1'b1;
        sb_q.push_back(model(a, b));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_a = op_a ^ 32'hA5A5_5A5A;
            op_b = op_b + 32'h0101_0101;
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && res_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R7 valid without pending item", {35'b0, res_valid}, 36'b0);
            end else begin
                logic [35:0] e;
                e = sb_q.pop_front();
                last_exp = e;
                chk(res[31:16] == e[31:16], "R1 upper lane", {20'b0, res[31:16]}, {20'b0, e[31:16]});
                chk(res[15:0]  == e[15:0],  "R2 lower lane", {20'b0, res[15:0]},  {20'b0, e[15:0]});
                chk(ge[3:2] == e[35:34], "R3 no-borrow pair", {34'b0, ge[3:2]}, {34'b0, e[35:34]});
                chk(ge[1:0] == e[33:32], "R4 carry pair",     {34'b0, ge[1:0]}, {34'b0, e[33:32]});
                chk(ge[3] == ge[2] && ge[1] == ge[0], "R5 pair coherence", {32'b0, ge}, {32'b0, e[35:32]});
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R6: reset state
        repeat (3) @(negedge clk);
        chk(res == '0 && ge == '0 && !res_valid, "R6 reset state", {ge, res}, 36'b0);
        rst = 1'b0;

        // typical values
        send(32'h5000_1234, 32'h0002_1000);
        send(32'h0001_F000, 32'h2000_0003);
        idle(2);
        // R9 corners: equal upper vs swapped lower, and lower sum of 0x10000
        send(32'h1234_8000, 32'h8000_1234);
        // upper wrap with borrow: 0 - 1
        send(32'h0000_0000, 32'h0000_0001);
        // all ones
        send(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        idle(2);
        chk(sb_q.size() == 0, "R7 all items delivered", {4'b0, 32'(sb_q.size())}, 36'b0);

        // R9 explicit: check ports directly
        send(32'hABCD_0001, 32'hFFFF_ABCD);
        @(negedge clk); in_valid = 1'b0;
        chk(res == 32'h0000_0000 && ge == 4'b1111, "R9 zero results with both pairs set",
            {ge, res}, {4'b1111, 32'h0});

        // R8: hold while idle with changing operands, R7: no valid
        idle(1);
        for (int i = 0; i < 4; i++) begin
            chk(res == last_exp[31:0] && ge == last_exp[35:32], "R8 hold while idle",
                {ge, res}, last_exp);
            chk(!res_valid, "R7 valid low when idle", {35'b0, res_valid}, 36'b0);
            idle(1);
        end

        // pseudo-random back-to-back run
        for (int i = 0; i < 40; i++) send($urandom, $urandom);
        for (int i = 0; i < 10; i++) begin
            send($urandom, $urandom);
            idle(1);
        end
        idle(3);
        chk(sb_q.size() == 0, "R7 random items delivered", {4'b0, 32'(sb_q.size())}, 36'b0);

        // R6: reset mid-run after a nonzero result
        send(32'h9000_0001, 32'h0001_0001);
        @(negedge clk); in_valid = 1'b0; rst = 1'b1;
        sb_q.delete();
        @(negedge clk);
        chk(res == '0 && ge == '0 && !res_valid, "R6 mid-run reset", {ge, res}, 36'b0);
        rst = 1'b0;
        idle(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule